// File: doc/BRIEF.md
# Register Init Command Sequencer

This block walks a list of 64-bit initialisation commands held in a synchronous command memory and carries each one out on a simple register bus. The bus has separate write and read strobes and a ready handshake. A start pulse begins execution at command index 0. Execution ends with a one-cycle done pulse once the index reaches the programmed command count, or sooner if an error occurs. An error flag accompanies that done pulse.

Each command holds a low word in bits 31:0 and a high word in bits 63:32. The command types are:
- register writes, either of an inline value or of a run of zeros;
- register reads, which may poll until a condition holds;
- two conditional forms that skip a number of following commands when the current mode or phase does not match;
- a microsecond wait driven by a tick input;
- a callback handshake with external logic.

The mode expression is evaluated outside the block and arrives as a single match bit.

Top module: `init_cmd_seq`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, err_o, cmd_rd_o, bus_wr_o, bus_rd_o and cb_req_o are all low.
- R2: start_i while idle starts execution at command index 0. When the index is at or beyond cmd_count_i, done_o pulses for exactly one cycle and the block returns to idle. A count of 0 finishes without any command fetch. start_i while busy has no effect.
- R3: Opcode 1 (bits 3:0) with source 0 (bits 6:4) writes the high word to the dword address in bits 31:9.
- R4: Opcode 1 with source 1 writes zero to N consecutive addresses, starting at bits 31:9, where N is the high word. N = 0 writes nothing.
- R5: bus_wr_o or bus_rd_o stays asserted, with stable address and data, until bus_ready_i is seen high. Each accepted write is one transfer.
- R6: Opcode 0 with poll type 0 (bits 7:4) performs exactly one read of the address in bits 31:9 and moves on.
- R7: Poll types 1, 2 and 3 re-read until the condition holds. Type 1 needs read equal to expected (high word). Type 2 needs (read AND expected) non-zero. Type 3 needs (read AND expected) equal to expected.
- R8: A poll that fails on poll_limit_i+1 consecutive reads ends execution with err_o set. No further command runs.
- R9: Opcode 2 skips the next K commands (K = bits 31:16) when mode_match_i is low. When it is high, no command is skipped. A skip past the count ends execution without error.
- R10: Opcode 3 skips the next K commands unless phase_i equals high-word bits 7:0 and the ID in high-word bits 31:16 equals phase_id_i. An ID of 0xFFFF matches any phase_id_i.
- R11: Opcode 4 waits for N pulses of us_tick_i (N = high word) before the next command. N = 0 does not wait.
- R12: Opcode 5 raises cb_req_o with cb_id_o = high-word bits 15:0 and cb_blk_o = high-word bits 31:16. These are held until cb_ack_i, and execution then continues.
- R13: Opcodes 6 to 15, write sources 2 to 7, and poll types 4 to 15 end execution with err_o set, and the offending command makes no bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin execution at index 0 |
| cmd_count_i | input | IDX_W+1 | Number of commands in the list |
| mode_match_i | input | 1 | Result of the external mode expression |
| phase_i | input | 8 | Current init phase |
| phase_id_i | input | 16 | Current phase ID |
| poll_limit_i | input | POLL_W | Extra reads allowed before a poll times out |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| cmd_rd_o | output | 1 | Command memory read strobe |
| cmd_addr_o | output | IDX_W | Command memory index |
| cmd_data_i | input | 64 | Command word, valid the cycle after cmd_rd_o |
| bus_wr_o | output | 1 | Register write strobe |
| bus_rd_o | output | 1 | Register read strobe |
| bus_addr_o | output | 23 | Register dword address |
| bus_wdata_o | output | 32 | Register write data |
| bus_rdata_i | input | 32 | Register read data, valid with bus_ready_i |
| bus_ready_i | input | 1 | Transfer accepted |
| cb_req_o | output | 1 | Callback request |
| cb_id_o | output | 16 | Callback identifier |
| cb_blk_o | output | 16 | Callback block identifier |
| cb_ack_i | input | 1 | Callback acknowledge |
| busy_o | output | 1 | Execution in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Run ended in error, valid with done_o |

## Verification
The hardest case to reach from the ports is a poll that keeps failing until the retry limit runs out. A failing read is never visible as such at the ports, so the only evidence is the number of reads and the error at done. The bench's bus model returns a failing value for a chosen number of reads before switching to a passing one. By setting the switch point before, at and beyond the retry limit, it checks the exact read count and the error outcome. Skips that jump past the end of the list are reached with a short list and a large skip count.

// File: rtl/ics_pkg.sv
package ics_pkg;
  localparam logic [3:0] OP_READ     = 4'd0;
  localparam logic [3:0] OP_WRITE    = 4'd1;
  localparam logic [3:0] OP_IFMODE   = 4'd2;
  localparam logic [3:0] OP_IFPHASE  = 4'd3;
  localparam logic [3:0] OP_DELAY    = 4'd4;
  localparam logic [3:0] OP_CALLBACK = 4'd5;

  localparam logic [2:0] SRC_INLINE = 3'd0;
  localparam logic [2:0] SRC_ZEROS  = 3'd1;

  localparam logic [3:0] POLL_NONE = 4'd0;
  localparam logic [3:0] POLL_EQ   = 4'd1;
  localparam logic [3:0] POLL_ANY  = 4'd2;
  localparam logic [3:0] POLL_ALL  = 4'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_FETCH, S_LATCH, S_EXEC,
    S_WRITE, S_READ, S_WAIT, S_CALL, S_DONE
  } seq_state_e;

  typedef struct packed {
    logic [3:0]  op;
    logic [2:0]  src;
    logic [3:0]  ptype;
    logic [22:0] addr;
    logic [15:0] skip;
    logic [31:0] arg;
    logic [7:0]  phase;
    logic [15:0] phase_id;
    logic [15:0] cb_id;
    logic [15:0] blk_id;
    logic        bad;
  } cmd_t;
endpackage

// File: rtl/ics_rst_sync.sv
module ics_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ics_decode.sv
module ics_decode
  import ics_pkg::*;
(
  input  logic [63:0] cmd_i,
  output cmd_t        fld_o
);
  logic unused_wide;
  assign unused_wide = cmd_i[8];

  always_comb begin
    fld_o.op       = cmd_i[3:0];
    fld_o.src      = cmd_i[6:4];
    fld_o.ptype    = cmd_i[7:4];
    fld_o.addr     = cmd_i[31:9];
    fld_o.skip     = cmd_i[31:16];
    fld_o.arg      = cmd_i[63:32];
    fld_o.phase    = cmd_i[39:32];
    fld_o.phase_id = cmd_i[63:48];
    fld_o.cb_id    = cmd_i[47:32];
    fld_o.blk_id   = cmd_i[63:48];
    fld_o.bad      = (fld_o.op > OP_CALLBACK)
                   || (fld_o.op == OP_WRITE && fld_o.src > SRC_ZEROS)
                   || (fld_o.op == OP_READ  && fld_o.ptype > POLL_ALL);
  end
endmodule

// File: rtl/ics_cond.sv
module ics_cond (
  input  logic        is_phase_i,
  input  logic        mode_match_i,
  input  logic [7:0]  cmd_phase_i,
  input  logic [15:0] cmd_phase_id_i,
  input  logic [7:0]  cur_phase_i,
  input  logic [15:0] cur_phase_id_i,
  output logic        met_o
);
  logic id_ok;
  assign id_ok = (cmd_phase_id_i == 16'hFFFF) || (cmd_phase_id_i == cur_phase_id_i);
  assign met_o = is_phase_i ? ((cmd_phase_i == cur_phase_i) && id_ok) : mode_match_i;
endmodule

// File: rtl/ics_poll.sv
module ics_poll
  import ics_pkg::*;
(
  input  logic [3:0]  ptype_i,
  input  logic [31:0] expect_i,
  input  logic [31:0] rdata_i,
  output logic        pass_o
);
  logic [31:0] masked;
  assign masked = rdata_i & expect_i;

  always_comb begin
    unique case (ptype_i)
      POLL_EQ:  pass_o = (rdata_i == expect_i);
      POLL_ANY: pass_o = (masked != '0);
      POLL_ALL: pass_o = (masked == expect_i);
      default:  pass_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/init_cmd_seq.sv
module init_cmd_seq
  import ics_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int POLL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IDX_W:0]    cmd_count_i,
  input  logic              mode_match_i,
  input  logic [7:0]        phase_i,
  input  logic [15:0]       phase_id_i,
  input  logic [POLL_W-1:0] poll_limit_i,
  input  logic              us_tick_i,
  output logic              cmd_rd_o,
  output logic [IDX_W-1:0]  cmd_addr_o,
  input  logic [63:0]       cmd_data_i,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  output logic [22:0]       bus_addr_o,
  output logic [31:0]       bus_wdata_o,
  input  logic [31:0]       bus_rdata_i,
  input  logic              bus_ready_i,
  output logic              cb_req_o,
  output logic [15:0]       cb_id_o,
  output logic [15:0]       cb_blk_o,
  input  logic              cb_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int XW = ((IDX_W > 16) ? IDX_W : 16) + 2;

  logic              rst_sync_n;
  seq_state_e        state_q, state_n;
  logic [XW-1:0]     idx_q, idx_n, idx_inc;
  logic [63:0]       cmd_q;
  logic              cmd_ld;
  logic [22:0]       addr_q, addr_n;
  logic [31:0]       cnt_q, cnt_n;
  logic [POLL_W-1:0] try_q, try_n;
  logic              err_q, err_n;
  cmd_t              fld;
  logic              cond_met, poll_pass;

  ics_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  ics_decode u_dec (.cmd_i(cmd_q), .fld_o(fld));

  ics_cond u_cond (
    .is_phase_i     (fld.op == OP_IFPHASE),
    .mode_match_i   (mode_match_i),
    .cmd_phase_i    (fld.phase),
    .cmd_phase_id_i (fld.phase_id),
    .cur_phase_i    (phase_i),
    .cur_phase_id_i (phase_id_i),
    .met_o          (cond_met)
  );

  ics_poll u_poll (
    .ptype_i  (fld.ptype),
    .expect_i (fld.arg),
    .rdata_i  (bus_rdata_i),
    .pass_o   (poll_pass)
  );

  assign idx_inc = idx_q + XW'(1);

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    cmd_ld  = 1'b0;
    addr_n  = addr_q;
    cnt_n   = cnt_q;
    try_n   = try_q;
    err_n   = err_q;
    case (state_q)
      S_IDLE: if (start_i) begin
        idx_n   = '0;
        err_n   = 1'b0;
        state_n = S_CHECK;
      end
      S_CHECK: state_n = (idx_q >= XW'(cmd_count_i)) ? S_DONE : S_FETCH;
      S_FETCH: state_n = S_LATCH;
      S_LATCH: begin
        cmd_ld  = 1'b1;
        state_n = S_EXEC;
      end
      S_EXEC: begin
        if (fld.bad) begin
          err_n   = 1'b1;
          state_n = S_DONE;
        end else begin
          idx_n   = idx_inc;
          state_n = S_CHECK;
          case (fld.op)
            OP_READ: begin
              addr_n  = fld.addr;
              try_n   = '0;
              idx_n   = idx_q;
              state_n = S_READ;
            end
            OP_WRITE: begin
              addr_n = fld.addr;
              cnt_n  = (fld.src == SRC_INLINE) ? 32'd1 : fld.arg;
              if (cnt_n != '0) begin
                idx_n   = idx_q;
                state_n = S_WRITE;
              end
            end
            OP_IFMODE, OP_IFPHASE:
              if (!cond_met) idx_n = idx_inc + XW'(fld.skip);
            OP_DELAY: begin
              cnt_n = fld.arg;
              if (fld.arg != '0) begin
                idx_n   = idx_q;
                state_n = S_WAIT;
              end
            end
            default: begin
              idx_n   = idx_q;
              state_n = S_CALL;
            end
          endcase
        end
      end
      S_WRITE: if (bus_ready_i) begin
        if (cnt_q == 32'd1) begin
          idx_n   = idx_inc;
          state_n = S_CHECK;
        end else begin
          cnt_n  = cnt_q - 32'd1;
          addr_n = addr_q + 23'd1;
        end
      end
      S_READ: if (bus_ready_i) begin
        if (fld.ptype == POLL_NONE || poll_pass) begin
          idx_n   = idx_inc;
          state_n = S_CHECK;
        end else if (try_q == poll_limit_i) begin
          err_n   = 1'b1;
          state_n = S_DONE;
        end else begin
          try_n = try_q + POLL_W'(1);
        end
      end
      S_WAIT: if (us_tick_i) begin
        if (cnt_q == 32'd1) begin
          idx_n   = idx_inc;
          state_n = S_CHECK;
        end else begin
          cnt_n = cnt_q - 32'd1;
        end
      end
      S_CALL: if (cb_ack_i) begin
        idx_n   = idx_inc;
        state_n = S_CHECK;
      end
      S_DONE:  state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      cmd_q   <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      try_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      if (cmd_ld) cmd_q <= cmd_data_i;
      addr_q  <= addr_n;
      cnt_q   <= cnt_n;
      try_q   <= try_n;
      err_q   <= err_n;
    end
  end

  assign cmd_rd_o    = (state_q == S_FETCH);
  assign cmd_addr_o  = idx_q[IDX_W-1:0];
  assign bus_wr_o    = (state_q == S_WRITE);
  assign bus_rd_o    = (state_q == S_READ);
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = (fld.src == SRC_INLINE) ? fld.arg : '0;
  assign cb_req_o    = (state_q == S_CALL);
  assign cb_id_o     = fld.cb_id;
  assign cb_blk_o    = fld.blk_id;
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_DONE);
  assign err_o       = done_o & err_q;
endmodule

// File: rtl/ics_chk.sv
module ics_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr_o,
  input logic        bus_rd_o,
  input logic        bus_ready_i,
  input logic [22:0] bus_addr_o,
  input logic [31:0] bus_wdata_o,
  input logic        cmd_rd_o,
  input logic        cb_req_o,
  input logic        cb_ack_i,
  input logic [15:0] cb_id_o,
  input logic [15:0] cb_blk_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o
);
  a_r5_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_o && !bus_ready_i |=> bus_wr_o && $stable(bus_addr_o) && $stable(bus_wdata_o));

  a_r5_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_o && !bus_ready_i |=> bus_rd_o && $stable(bus_addr_o));

  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_o && bus_rd_o));

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !bus_wr_o && !bus_rd_o && !cmd_rd_o && !cb_req_o && !done_o);

  a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  a_r12_cb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cb_req_o && !cb_ack_i |=> cb_req_o && $stable(cb_id_o) && $stable(cb_blk_o));
endmodule

bind init_cmd_seq ics_chk i_chk (
  .clk(clk), .rst_n(rst_n),
  .bus_wr_o(bus_wr_o), .bus_rd_o(bus_rd_o), .bus_ready_i(bus_ready_i),
  .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
  .cmd_rd_o(cmd_rd_o), .cb_req_o(cb_req_o), .cb_ack_i(cb_ack_i),
  .cb_id_o(cb_id_o), .cb_blk_o(cb_blk_o),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/test_init_cmd_seq.sv
module test_init_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W  = 8;
  localparam int POLL_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [IDX_W:0] cmd_count_i = '0;
  logic mode_match_i = 1'b0;
  logic [7:0] phase_i = '0;
  logic [15:0] phase_id_i = '0;
  logic [POLL_W-1:0] poll_limit_i = '0;
  logic us_tick_i = 1'b0;
  logic cmd_rd_o;
  logic [IDX_W-1:0] cmd_addr_o;
  logic [63:0] cmd_data_i = '0;
  logic bus_wr_o, bus_rd_o;
  logic [22:0] bus_addr_o;
  logic [31:0] bus_wdata_o;
  logic [31:0] bus_rdata_i = '0;
  logic bus_ready_i = 1'b0;
  logic cb_req_o;
  logic [15:0] cb_id_o, cb_blk_o;
  logic cb_ack_i = 1'b0;
  logic busy_o, done_o, err_o;

  init_cmd_seq #(.IDX_W(IDX_W), .POLL_W(POLL_W)) i_init_cmd_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [63:0] mem [0:255];
  int n_chk = 0, n_bad = 0, cyc = 0;
  int fetch_cnt, wcnt, rcnt, done_cnt, cb_cnt, tick_cnt;
  int lat, bus_lat = 2, cbw, tdiv = 0;
  int flip_at = 0;
  logic [31:0] bad_val = '0, good_val = '0;
  logic [22:0] wlog_a [0:31];
  logic [31:0] wlog_d [0:31];
  logic [22:0] rlast_a;
  logic [31:0] got_cb;
  logic last_err;

  always @(negedge clk) begin
    if (cmd_rd_o) begin
      cmd_data_i = mem[cmd_addr_o];
      fetch_cnt++;
    end
    if (bus_ready_i) begin
      bus_ready_i = 1'b0;
      lat = 0;
    end else if (bus_wr_o || bus_rd_o) begin
      if (lat >= bus_lat) begin
        if (bus_wr_o) begin
          if (wcnt < 32) begin
            wlog_a[wcnt] = bus_addr_o;
            wlog_d[wcnt] = bus_wdata_o;
          end
          wcnt++;
        end else begin
          bus_rdata_i = (rcnt >= flip_at) ? good_val : bad_val;
          rlast_a = bus_addr_o;
          rcnt++;
        end
        bus_ready_i = 1'b1;
      end else lat++;
    end
    if (cb_ack_i) begin
      cb_ack_i = 1'b0;
      cbw = 0;
    end else if (cb_req_o) begin
      if (cbw == 5) begin
        cb_ack_i = 1'b1;
        got_cb = {cb_blk_o, cb_id_o};
        cb_cnt++;
      end else cbw++;
    end
    us_tick_i = (tdiv == 3);
    tdiv = (tdiv + 1) % 4;
    if (us_tick_i && busy_o) tick_cnt++;
    if (done_o) begin
      done_cnt++;
      last_err = err_o;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_wr(input logic [22:0] a, input logic [2:0] s, input logic [31:0] v);
    return {v, a, 2'b00, s, 4'd1};
  endfunction
  function automatic logic [63:0] mk_rd(input logic [22:0] a, input logic [3:0] p, input logic [31:0] e);
    return {e, a, 1'b0, p, 4'd0};
  endfunction
  function automatic logic [63:0] mk_ifm(input logic [15:0] k);
    return {32'd0, k, 12'd0, 4'd2};
  endfunction
  function automatic logic [63:0] mk_ifp(input logic [15:0] k, input logic [7:0] ph, input logic [15:0] id);
    return {id, 8'd0, ph, k, 12'd0, 4'd3};
  endfunction
  function automatic logic [63:0] mk_dly(input logic [31:0] n);
    return {n, 28'd0, 4'd4};
  endfunction
  function automatic logic [63:0] mk_cb(input logic [15:0] id, input logic [15:0] blk);
    return {blk, id, 28'd0, 4'd5};
  endfunction

  task automatic tick_wait(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic run_prog(input int count, input bit poke);
    fetch_cnt = 0; wcnt = 0; rcnt = 0; done_cnt = 0; cb_cnt = 0; tick_cnt = 0;
    last_err = 1'b0;
    cmd_count_i = (IDX_W+1)'(count);
    start_i = 1'b1;
    tick_wait(1);
    start_i = 1'b0;
    if (poke) begin
      tick_wait(3);
      start_i = 1'b1;
      tick_wait(1);
      start_i = 1'b0;
    end
    for (int i = 0; i < 3000 && done_cnt == 0; i++) tick_wait(1);
    tick_wait(4);
    check(done_cnt == 1, "R2", "done pulses", done_cnt, 1);
  endtask

  task automatic t_reset;
    check(!busy_o && !done_o && !err_o && !cmd_rd_o && !bus_wr_o && !bus_rd_o && !cb_req_o,
          "R1", "outputs in reset", {busy_o, done_o, err_o, cmd_rd_o, bus_wr_o, bus_rd_o, cb_req_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    tick_wait(4);
    check(!busy_o && !done_o && !cmd_rd_o && !bus_wr_o && !bus_rd_o && !cb_req_o,
          "R1", "outputs after reset", {busy_o, done_o, cmd_rd_o, bus_wr_o, bus_rd_o, cb_req_o}, 0);
  endtask

  task automatic t_empty;
    run_prog(0, 1'b0);
    check(fetch_cnt == 0, "R2", "fetches with count 0", fetch_cnt, 0);
    check(last_err == 1'b0, "R2", "err with count 0", last_err, 0);
  endtask

  task automatic t_writes;
    mem[0] = mk_wr(23'h123, 3'd0, 32'hDEADBEEF);
    mem[1] = mk_wr(23'h40, 3'd1, 32'd3);
    mem[2] = mk_wr(23'h55, 3'd1, 32'd0);
    mem[3] = mk_wr(23'h7FFFFF, 3'd0, 32'd1);
    run_prog(4, 1'b1);
    check(fetch_cnt == 4, "R2", "fetch count", fetch_cnt, 4);
    check(wcnt == 5, "R4", "write count", wcnt, 5);
    check(wlog_a[0] == 23'h123 && wlog_d[0] == 32'hDEADBEEF, "R3", "inline write", {wlog_a[0], wlog_d[0]}, {23'h123, 32'hDEADBEEF});
    for (int i = 0; i < 3; i++)
      check(wlog_a[1+i] == 23'h40 + 23'(i) && wlog_d[1+i] == 0, "R4", "zero run entry",
            {wlog_a[1+i], wlog_d[1+i]}, {23'h40 + 23'(i), 32'd0});
    check(wlog_a[4] == 23'h7FFFFF && wlog_d[4] == 1, "R5", "last write after zero-length run", {wlog_a[4], wlog_d[4]}, {23'h7FFFFF, 32'd1});
    check(last_err == 1'b0, "R3", "err after writes", last_err, 0);
  endtask

  task automatic run_poll(input logic [3:0] pt, input logic [31:0] exp_v, input logic [31:0] bv,
                          input logic [31:0] gv, input int flip, input int limit,
                          input int exp_reads, input bit exp_err, input string req);
    bad_val = bv; good_val = gv; flip_at = flip;
    poll_limit_i = POLL_W'(limit);
    mem[0] = mk_rd(23'h2A5, pt, exp_v);
    mem[1] = mk_wr(23'h9, 3'd0, 32'h99);
    run_prog(2, 1'b0);
    check(rcnt == exp_reads, req, "read count", rcnt, exp_reads);
    check(rlast_a == 23'h2A5, req, "read address", rlast_a, 23'h2A5);
    check(last_err == exp_err, req, "err", last_err, exp_err);
    check(wcnt == (exp_err ? 0 : 1), req, "following write", wcnt, exp_err ? 0 : 1);
  endtask

  task automatic t_poll;
    run_poll(4'd0, 32'h0, 32'h0, 32'h0, 99, 3, 1, 1'b0, "R6");
    run_poll(4'd1, 32'h55, 32'h54, 32'h55, 2, 5, 3, 1'b0, "R7");
    run_poll(4'd2, 32'h10, 32'h0F, 32'h30, 1, 5, 2, 1'b0, "R7");
    run_poll(4'd3, 32'h0C, 32'h04, 32'h0E, 3, 5, 4, 1'b0, "R7");
    run_poll(4'd1, 32'h1, 32'h0, 32'h1, 99, 2, 3, 1'b1, "R8");
    run_poll(4'd1, 32'h1, 32'h0, 32'h1, 2, 2, 3, 1'b0, "R8");
  endtask

  task automatic t_ifmode;
    mem[0] = mk_ifm(16'd2);
    mem[1] = mk_wr(23'h10, 3'd0, 32'hA);
    mem[2] = mk_wr(23'h11, 3'd0, 32'hB);
    mem[3] = mk_wr(23'h12, 3'd0, 32'hC);
    mode_match_i = 1'b0;
    run_prog(4, 1'b0);
    check(wcnt == 1 && wlog_a[0] == 23'h12, "R9", "mismatch skips two", {wcnt[7:0], wlog_a[0]}, {8'd1, 23'h12});
    mode_match_i = 1'b1;
    run_prog(4, 1'b0);
    check(wcnt == 3, "R9", "match skips none", wcnt, 3);
    mem[0] = mk_ifm(16'd5);
    mode_match_i = 1'b0;
    run_prog(2, 1'b0);
    check(wcnt == 0 && last_err == 0, "R9", "skip past end", {wcnt[7:0], last_err}, 0);
  endtask

  task automatic one_phase(input logic [15:0] cmd_id, input logic [7:0] ph, input logic [15:0] id, input int exp_w);
    mem[0] = mk_ifp(16'd1, 8'd2, cmd_id);
    mem[1] = mk_wr(23'h10, 3'd0, 32'hA);
    mem[2] = mk_wr(23'h11, 3'd0, 32'hB);
    phase_i = ph;
    phase_id_i = id;
    run_prog(3, 1'b0);
    check(wcnt == exp_w && wlog_a[wcnt-1] == 23'h11, "R10", "phase skip result", wcnt, exp_w);
  endtask

  task automatic t_ifphase;
    one_phase(16'd7, 8'd2, 16'd7, 2);
    one_phase(16'd7, 8'd2, 16'd8, 1);
    one_phase(16'hFFFF, 8'd2, 16'd8, 2);
    one_phase(16'd7, 8'd3, 16'd7, 1);
  endtask

  task automatic t_delay;
    mem[0] = mk_dly(32'd10);
    run_prog(1, 1'b0);
    check(tick_cnt >= 10 && tick_cnt <= 12, "R11", "ticks during 10us wait", tick_cnt, 10);
    mem[0] = mk_dly(32'd0);
    run_prog(1, 1'b0);
    check(tick_cnt <= 2, "R11", "ticks during zero wait", tick_cnt, 0);
  endtask

  task automatic t_callback;
    mem[0] = mk_cb(16'h1234, 16'hABCD);
    mem[1] = mk_wr(23'h20, 3'd0, 32'h77);
    run_prog(2, 1'b0);
    check(cb_cnt == 1 && got_cb == 32'hABCD1234, "R12", "callback ids", got_cb, 32'hABCD1234);
    check(wcnt == 1 && wlog_d[0] == 32'h77, "R12", "continue after ack", wlog_d[0], 32'h77);
  endtask

  task automatic t_illegal;
    mem[0] = {32'd0, 28'd0, 4'd7};
    mem[1] = mk_wr(23'h30, 3'd0, 32'h1);
    run_prog(2, 1'b0);
    check(last_err == 1 && wcnt == 0, "R13", "bad opcode", {last_err, wcnt[7:0]}, {1'b1, 8'd0});
    mem[0] = mk_wr(23'h5, 3'd2, 32'h9);
    run_prog(2, 1'b0);
    check(last_err == 1 && wcnt == 0, "R13", "unsupported source", {last_err, wcnt[7:0]}, {1'b1, 8'd0});
    mem[0] = mk_rd(23'h5, 4'd6, 32'h9);
    run_prog(2, 1'b0);
    check(last_err == 1 && rcnt == 0, "R13", "bad poll type", {last_err, rcnt[7:0]}, {1'b1, 8'd0});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    tick_wait(3);
    t_reset();
    t_empty();
    t_writes();
    t_poll();
    t_ifmode();
    t_ifphase();
    t_delay();
    t_callback();
    t_illegal();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule